// File: doc/BRIEF.md
# SPI Auto-Readback and Command Key Unit

This unit is the serial front end of a register-slave device. It deframes 32-bit SPI transactions into register-file writes. On every frame it shifts out a return word. That word is either a status snapshot or, when auto-readback is on, the address and contents of one preselected register. The return is independent of the write being carried in, so a host polling a register costs no extra read frames.

If the frame-select line stays low across several frames, the unit streams. Each further frame in the burst returns the next register address. Two addresses are decoded locally and are never forwarded. One holds the readback pointer and its enable. The other is a command register that fires a software reset as soon as its two-key sequence is complete. The reset-request pulse feeds the same reset path as the external reset pin, and the unit clears its own state with it.

The SPI pins are oversampled in the system clock domain, so the serial clock must be several times slower than the system clock.

Top module: `spi_rb_unit`

## Requirements
- R1: A frame is 32 bits, MSB first, SPI mode 1: input sampled on SCLK falling edges and output changed on rising edges. Bits [31:24] are the target address, [23:8] the data and [7:0] a CRC byte that is ignored without checking. A frame acts only once its 32nd bit is sampled; raising select earlier discards it.
- R2: A completed frame to any non-local address produces a single-cycle `wr_en_o` with `wr_addr_o`/`wr_data_o` taken from the frame.
- R3: Address 0x6E is the readback control register (data[7:0] readback address, data[8] auto-readback enable). Address 0x44 is the command register. Frames to either are never forwarded on the write port.
- R4: With auto-readback off, the returned word is {8'h00, status_i, 8'h00}.
- R5: With auto-readback on, the returned word is {A, rd_data_i, 8'h00}, where A is the readback address and is also presented on `rd_addr_o`.
- R6: Single frames separated by select going high all return the same register until the control register is rewritten.
- R7: In a burst with select held low, frame k (k = 0, 1, …) returns address A+k modulo 256. The offset restarts at 0 when select rises.
- R8: Writing 0x15FA and then 0xAF51 to the command register in consecutive command writes produces a one-cycle `rst_req_o` pulse with no further frame needed.
- R9: Any other value written to the command register between the two keys aborts the sequence. 0xAF51 alone does nothing. A repeated 0x15FA keeps the sequence armed.
- R10: After `rst_req_o`, the unit is in its `rst_ni` state: auto-readback off, readback address 0, key sequence idle, stream offset 0. This holds even inside an ongoing burst.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| spi_sclk_i | input | 1 | SPI clock, idle low |
| spi_cs_ni | input | 1 | Frame select, active low |
| spi_mosi_i | input | 1 | Serial data in |
| spi_miso_o | output | 1 | Serial data out |
| status_i | input | 16 | Status word returned when auto-readback is off |
| rd_addr_o | output | 8 | Register-file read address (readback address plus stream offset) |
| rd_data_i | input | 16 | Register-file read data for `rd_addr_o` |
| wr_en_o | output | 1 | Register-file write strobe |
| wr_addr_o | output | 8 | Register-file write address |
| wr_data_o | output | 16 | Register-file write data |
| rst_req_o | output | 1 | Software reset request pulse |

## Verification
The completion of the key sequence and the advance of the stream offset both happen on the same frame-commit cycle. So the reset pulse and an ongoing readback burst can collide. The bench provokes this by enabling auto-readback and then sending both keys followed by two more frames, all under one low select. It judges the result by requiring the frames after the reset to return the status word rather than the next streamed register. Random bursts of random length, pointer and enable then check address advance and wrap against a bench model of the register file.

// File: rtl/spi_rb_pkg.sv
package spi_rb_pkg;
  localparam int ADDR_W    = 8;
  localparam int DATA_W    = 16;
  localparam int CRC_W     = 8;
  localparam int PAYLOAD_W = ADDR_W + DATA_W;
  localparam int FRAME_W   = PAYLOAD_W + CRC_W;
  localparam int CNT_W     = $clog2(FRAME_W);

  typedef struct packed {
    logic [ADDR_W-1:0] addr;
    logic [DATA_W-1:0] data;
  } payload_t;
endpackage

// File: rtl/spi_rb_sync.sv
module spi_rb_sync #(
  parameter int               WIDTH   = 3,
  parameter int               STAGES  = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] stg [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) stg[s] <= RST_VAL;
      else         stg[s] <= (s == 0) ? d_i : stg[(s == 0) ? 0 : s-1];
    end
  end

  assign q_o = stg[STAGES-1];
endmodule

// File: rtl/spi_rb_shifter.sv
module spi_rb_shifter
  import spi_rb_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               clr_i,
  input  logic               cs_n_i,
  input  logic               sclk_i,
  input  logic               mosi_i,
  input  logic [FRAME_W-1:0] load_i,
  output logic               miso_o,
  output logic               done_o,
  output payload_t           payload_o
);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(FRAME_W - 1);
  localparam logic [CNT_W-1:0] PAY_BIT  = CNT_W'(PAYLOAD_W - 1);

  logic                 sclk_q;
  logic [CNT_W-1:0]     cnt;
  logic [PAYLOAD_W-2:0] rx;
  logic [FRAME_W-1:0]   tx;

  wire rise = sclk_i & ~sclk_q;
  wire fall = ~sclk_i & sclk_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sclk_q    <= 1'b0;
      cnt       <= '0;
      rx        <= '0;
      tx        <= '0;
      done_o    <= 1'b0;
      payload_o <= '0;
    end else begin
      sclk_q <= sclk_i;
      done_o <= 1'b0;
      if (clr_i || cs_n_i) begin
        cnt <= '0;
      end else begin
        // first rising edge of a frame loads the return word
        if (rise) tx <= (cnt == '0) ? load_i : {tx[FRAME_W-2:0], 1'b0};
        if (fall) begin
          rx  <= {rx[PAYLOAD_W-3:0], mosi_i};
          cnt <= (cnt == LAST_BIT) ? '0 : cnt + 1'b1;
          if (cnt == PAY_BIT)  payload_o <= {rx, mosi_i};
          if (cnt == LAST_BIT) done_o    <= 1'b1;
        end
      end
    end
  end

  assign miso_o = tx[FRAME_W-1];
endmodule

// File: rtl/spi_rb_keyseq.sv
module spi_rb_keyseq #(
  parameter int               DATA_W = 16,
  parameter logic [DATA_W-1:0] KEY0  = 16'h15FA,
  parameter logic [DATA_W-1:0] KEY1  = 16'hAF51
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic              wr_i,
  input  logic [DATA_W-1:0] key_i,
  output logic              fire_o
);
  logic armed;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      armed  <= 1'b0;
      fire_o <= 1'b0;
    end else begin
      fire_o <= 1'b0;
      if (clr_i) begin
        armed <= 1'b0;
      end else if (wr_i) begin
        if (armed && key_i == KEY1) begin
          fire_o <= 1'b1;
          armed  <= 1'b0;
        end else begin
          armed <= (key_i == KEY0);
        end
      end
    end
  end
endmodule

// File: rtl/spi_rb_unit.sv
module spi_rb_unit
  import spi_rb_pkg::*;
#(
  parameter logic [ADDR_W-1:0] RB_REG      = 8'h6E,
  parameter logic [ADDR_W-1:0] CMD_REG     = 8'h44,
  parameter logic [DATA_W-1:0] KEY0        = 16'h15FA,
  parameter logic [DATA_W-1:0] KEY1        = 16'hAF51,
  parameter int                SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              spi_sclk_i,
  input  logic              spi_cs_ni,
  input  logic              spi_mosi_i,
  output logic              spi_miso_o,
  input  logic [DATA_W-1:0] status_i,
  output logic [ADDR_W-1:0] rd_addr_o,
  input  logic [DATA_W-1:0] rd_data_i,
  output logic              wr_en_o,
  output logic [ADDR_W-1:0] wr_addr_o,
  output logic [DATA_W-1:0] wr_data_o,
  output logic              rst_req_o
);
  logic              cs_s, sclk_s, mosi_s;
  logic              done;
  payload_t          pl;
  logic [ADDR_W-1:0] rb_addr, stream_off;
  logic              ar_en;
  logic [FRAME_W-1:0] load_word;

  spi_rb_sync #(
    .WIDTH  (3),
    .STAGES (SYNC_STAGES),
    .RST_VAL(3'b100)
  ) i_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({spi_cs_ni, spi_sclk_i, spi_mosi_i}),
    .q_o   ({cs_s, sclk_s, mosi_s})
  );

  spi_rb_shifter i_shift (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .clr_i    (rst_req_o),
    .cs_n_i   (cs_s),
    .sclk_i   (sclk_s),
    .mosi_i   (mosi_s),
    .load_i   (load_word),
    .miso_o   (spi_miso_o),
    .done_o   (done),
    .payload_o(pl)
  );

  wire is_rb  = (pl.addr == RB_REG);
  wire is_cmd = (pl.addr == CMD_REG);

  spi_rb_keyseq #(
    .DATA_W(DATA_W),
    .KEY0  (KEY0),
    .KEY1  (KEY1)
  ) i_key (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .clr_i (rst_req_o),
    .wr_i  (done && is_cmd),
    .key_i (pl.data),
    .fire_o(rst_req_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rb_addr    <= '0;
      ar_en      <= 1'b0;
      stream_off <= '0;
      wr_en_o    <= 1'b0;
      wr_addr_o  <= '0;
      wr_data_o  <= '0;
    end else if (rst_req_o) begin
      // software reset: same state as the pin
      rb_addr    <= '0;
      ar_en      <= 1'b0;
      stream_off <= '0;
      wr_en_o    <= 1'b0;
      wr_addr_o  <= '0;
      wr_data_o  <= '0;
    end else begin
      wr_en_o <= 1'b0;
      if (done)      stream_off <= stream_off + 1'b1;
      else if (cs_s) stream_off <= '0;
      if (done) begin
        if (is_rb) begin
          rb_addr <= pl.data[ADDR_W-1:0];
          ar_en   <= pl.data[ADDR_W];
        end else if (!is_cmd) begin
          wr_en_o   <= 1'b1;
          wr_addr_o <= pl.addr;
          wr_data_o <= pl.data;
        end
      end
    end
  end

  assign rd_addr_o = rb_addr + stream_off;
  assign load_word = ar_en ? {rd_addr_o, rd_data_i, {CRC_W{1'b0}}}
                           : {{ADDR_W{1'b0}}, status_i, {CRC_W{1'b0}}};
endmodule

// File: rtl/spi_rb_unit_chk.sv
module spi_rb_unit_chk #(
  parameter logic [7:0] RB_REG  = 8'h6E,
  parameter logic [7:0] CMD_REG = 8'h44
) (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       wr_en_o,
  input logic [7:0] wr_addr_o,
  input logic [7:0] rd_addr_o,
  input logic       rst_req_o
);
  AST_WR_SINGLE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_o |=> !wr_en_o); // R2
  AST_WR_NOT_LOCAL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_o |-> (wr_addr_o != RB_REG && wr_addr_o != CMD_REG)); // R3
  AST_RST_REQ_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_req_o |=> !rst_req_o); // R8
  AST_RST_NO_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_req_o |-> !wr_en_o); // R3
  AST_SWRST_CLEARS_PTR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_req_o |=> (rd_addr_o == 8'h00)); // R10
endmodule

bind spi_rb_unit spi_rb_unit_chk #(
  .RB_REG (RB_REG),
  .CMD_REG(CMD_REG)
) i_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .wr_en_o  (wr_en_o),
  .wr_addr_o(wr_addr_o),
  .rd_addr_o(rd_addr_o),
  .rst_req_o(rst_req_o)
);

// File: tb/test_spi_rb_unit.sv
module test_spi_rb_unit;
  localparam int CLK_PERIOD = 10;
  localparam int HALF       = 8;
  localparam int WD_CYCLES  = 190000;
  localparam logic [7:0]  RB  = 8'h6E;
  localparam logic [7:0]  CMD = 8'h44;
  localparam logic [15:0] K0  = 16'h15FA;
  localparam logic [15:0] K1  = 16'hAF51;

  logic clk = 1'b0, rst_n = 1'b0;
  logic sclk = 1'b0, cs_n = 1'b1, mosi = 1'b0;
  logic miso, wr_en, rst_req;
  logic [15:0] st = 16'h0000, rd_data, wr_data;
  logic [7:0]  rd_addr, wr_addr;

  int tests = 0, fails = 0;
  int wr_cnt = 0, rst_cnt = 0, rst_hi = 0;
  logic [7:0]  last_wa = '0;
  logic [15:0] last_wd = '0;
  logic rst_q = 1'b0;
  bit done_flag = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [15:0] rf_val(input logic [7:0] a);
    return {a ^ 8'h5A, ~a};
  endfunction

  function automatic logic [31:0] exp_ret(input logic ar, input logic [7:0] a,
                                          input logic [15:0] s);
    return ar ? {a, rf_val(a), 8'h00} : {8'h00, s, 8'h00};
  endfunction

  assign rd_data = rf_val(rd_addr);

  spi_rb_unit i_spi_rb_unit (
    .clk_i(clk), .rst_ni(rst_n),
    .spi_sclk_i(sclk), .spi_cs_ni(cs_n), .spi_mosi_i(mosi), .spi_miso_o(miso),
    .status_i(st), .rd_addr_o(rd_addr), .rd_data_i(rd_data),
    .wr_en_o(wr_en), .wr_addr_o(wr_addr), .wr_data_o(wr_data),
    .rst_req_o(rst_req)
  );

  always @(negedge clk) begin
    if (wr_en) begin wr_cnt++; last_wa = wr_addr; last_wd = wr_data; end
    if (rst_req) rst_hi++;
    if (rst_req && !rst_q) rst_cnt++;
    rst_q = rst_req;
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic xfer(input logic [31:0] w, output logic [31:0] r);
    for (int i = 31; i >= 0; i--) begin
      sclk = 1'b1; mosi = w[i];
      repeat (HALF) @(negedge clk);
      r[i] = miso;
      sclk = 1'b0;
      repeat (HALF) @(negedge clk);
    end
  endtask

  task automatic cs_lo(); cs_n = 1'b0; repeat (HALF) @(negedge clk); endtask
  task automatic cs_hi(); cs_n = 1'b1; repeat (3*HALF) @(negedge clk); endtask

  task automatic single(input logic [7:0] a, input logic [15:0] d,
                        input logic [7:0] c, output logic [31:0] r);
    cs_lo(); xfer({a, d, c}, r); cs_hi();
  endtask

  function automatic logic [7:0] rnd_addr();
    logic [7:0] a = 8'($urandom);
    if (a == RB || a == CMD) a = a ^ 8'h01;
    return a;
  endfunction

  initial begin
    repeat (WD_CYCLES) @(posedge clk);
    if (!done_flag) begin
      fails++; tests++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] r;
    int seed, n, wc;
    logic [7:0] a, rbv;
    logic [15:0] d;
    logic ar;
    seed = $urandom(32'd5150);
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // reset state (R10) and status return with readback off (R4)
    chk("R10 reset wr_en", {31'd0, wr_en}, 32'd0);
    chk("R10 reset rst_req", {31'd0, rst_req}, 32'd0);
    st = 16'hC3A1;
    single(8'h10, 16'h1234, 8'h00, r);
    chk("R4 status return", r, exp_ret(1'b0, 8'h00, st));
    chk("R2 write addr/data", {8'h00, last_wa, last_wd}, {8'h00, 8'h10, 16'h1234});

    // CRC byte ignored (R1)
    single(8'h22, 16'hBEEF, 8'hA5, r);
    chk("R1 crc ignored", {8'h00, last_wa, last_wd}, {8'h00, 8'h22, 16'hBEEF});
    // partial frame discarded (R1)
    wc = wr_cnt;
    cs_lo();
    for (int i = 0; i < 16; i++) begin
      sclk = 1'b1; mosi = 1'b1; repeat (HALF) @(negedge clk);
      sclk = 1'b0; repeat (HALF) @(negedge clk);
    end
    cs_hi();
    single(8'h31, 16'h0F0F, 8'h00, r);
    chk("R1 partial frame dropped", wr_cnt - wc, 1);
    chk("R1 next frame intact", {8'h00, last_wa, last_wd}, {8'h00, 8'h31, 16'h0F0F});

    // local registers, auto-readback (R3, R5, R6)
    wc = wr_cnt;
    single(RB, 16'h0130, 8'h00, r);
    chk("R3 rb reg not forwarded", wr_cnt - wc, 0);
    single(8'h05, 16'h1111, 8'h00, r);
    chk("R5 readback word", r, exp_ret(1'b1, 8'h30, st));
    st = 16'h7777;
    single(8'h06, 16'h2222, 8'h00, r);
    chk("R6 same register again", r, exp_ret(1'b1, 8'h30, st));

    // streaming with wrap (R7)
    single(RB, 16'h01FE, 8'h00, r);
    cs_lo();
    for (int k = 0; k < 4; k++) begin
      xfer({8'h50, 16'(k), 8'h00}, r);
      chk("R7 stream advance/wrap", r, exp_ret(1'b1, 8'(8'hFE + k), st));
    end
    cs_hi();
    single(8'h50, 16'h0000, 8'h00, r);
    chk("R7 offset restart", r, exp_ret(1'b1, 8'hFE, st));

    // key sequence (R8)
    wc = wr_cnt;
    single(CMD, K0, 8'h00, r);
    chk("R8 no fire after first key", rst_cnt, 0);
    single(CMD, K1, 8'h00, r);
    chk("R8 fire after second key", rst_cnt, 1);
    chk("R8 one-cycle pulse", rst_hi, 1);
    chk("R3 cmd not forwarded", wr_cnt - wc, 0);
    single(8'h07, 16'h0000, 8'h00, r);
    chk("R10 readback off after sw reset", r, exp_ret(1'b0, 8'h00, st));

    // abort and arming (R9)
    single(CMD, K0, 8'h00, r);
    single(CMD, 16'h1111, 8'h00, r);
    single(CMD, K1, 8'h00, r);
    chk("R9 aborted sequence", rst_cnt, 1);
    single(CMD, K1, 8'h00, r);
    chk("R9 lone second key", rst_cnt, 1);
    single(CMD, K0, 8'h00, r);
    single(CMD, K0, 8'h00, r);
    single(CMD, K1, 8'h00, r);
    chk("R9 repeated first key stays armed", rst_cnt, 2);

    // reset colliding with a stream (R10, R7)
    single(RB, 16'h0140, 8'h00, r);
    st = 16'h5A5A;
    cs_lo();
    xfer({CMD, K0, 8'h00}, r);
    chk("R7 burst frame0", r, exp_ret(1'b1, 8'h40, st));
    xfer({CMD, K1, 8'h00}, r);
    chk("R7 burst frame1", r, exp_ret(1'b1, 8'h41, st));
    xfer({8'h09, 16'h0000, 8'h00}, r);
    chk("R10 reset inside burst", r, exp_ret(1'b0, 8'h00, st));
    xfer({8'h09, 16'h0000, 8'h00}, r);
    chk("R10 burst after reset", r, exp_ret(1'b0, 8'h00, st));
    cs_hi();
    chk("R8 burst fire", rst_cnt, 3);

    // random writes (R2)
    for (int t = 0; t < 25; t++) begin
      a = rnd_addr(); d = 16'($urandom);
      wc = wr_cnt;
      single(a, d, 8'($urandom), r);
      chk("R2 random write", {7'd0, 1'(wr_cnt - wc), a, d}, {7'd0, 1'b1, last_wa, last_wd});
    end

    // random bursts (R4, R5, R7)
    for (int t = 0; t < 20; t++) begin
      rbv = 8'($urandom); ar = 1'($urandom);
      single(RB, {7'd0, ar, rbv}, 8'h00, r);
      n = 1 + int'($urandom % 4);
      cs_lo();
      for (int k = 0; k < n; k++) begin
        st = 16'($urandom);
        xfer({rnd_addr(), 16'($urandom), 8'h00}, r);
        chk("R7 random burst", r, exp_ret(ar, 8'(rbv + k), st));
      end
      cs_hi();
    end

    done_flag = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule